// File: doc/BRIEF.md
# Nine-Pin Open-Drain I/O Expander Register Bank

This block puts nine general-purpose pins behind a byte-wide synchronous register port. Each pin has three independent parts: a low-side driver that either pulls the pin to ground or releases it, an internal pull-up enable, and an input path whose level software can read. None of the pins can ever drive high. A released pin with its pull-up enabled rises through the resistor. A released pin without its pull-up floats, unless something outside the block pulls it.

Software controls the pins by writing bytes. There are two byte registers for the pull-up enables and two for the driver controls. Pins 0 to 7 sit in the low byte of each pair, and pin 8 sits in bit 0 of the high byte. Reading the control or pull-up registers back returns the stored settings. Reading the two status addresses returns the live pin levels, after each level has passed through a two-flop synchronizer. Read data is combinational from the address, so a read has no side effect.

The block has no state machine. Its only state is the two nine-bit setting registers and the synchronizer. Address decoding is a single `unique case` on the register address. There are no named states and no transitions between them.

Top module: `gpx_bank`

## Requirements
- R1: After reset, every driver is released (`pin_drive_low` = 0) and every pull-up is off (`pin_pullup_en` = 0). Reads then return 00h at F0h and F1h, FFh at F2h and 01h at F3h.
- R2: A write to F0h sets the pull-up enables of pins 0-7 from data bits 0-7. A write to F1h sets the pull-up enable of pin 8 from data bit 0. Both take effect on `pin_pullup_en` at the clock edge that accepts the write.
- R3: A write to F2h sets the control bits of pins 0-7, and a write to F3h sets the control bit of pin 8 from data bit 0. A control bit of 0 asserts `pin_drive_low` for that pin, and a control bit of 1 releases the pin. The change appears at the accepting edge.
- R4: Reads of F0h-F3h return the stored bits. Bits 7:1 of F1h and F3h always read 0, and writes to those bits have no effect.
- R5: A read of F8h returns the synchronized levels of pins 0-7. A read of F9h returns the level of pin 8 in bit 0 and zeros in bits 7:1. A level applied before clock edge k is visible after edge k+1, and not after edge k.
- R6: F8h and F9h are read-only. Writes to them change no output and no stored register.
- R7: A read of any address other than F0h-F3h, F8h or F9h returns 00h. A write to such an address changes nothing.
- R8: Reading is free of side effects. `reg_rdata` follows `reg_addr` within the same cycle, and repeated reads return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, sampled at the rising edge |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| pin_level | input | 9 | Raw pin levels, asynchronous |
| pin_drive_low | output | 9 | 1 = pull the pin low, 0 = release it |
| pin_pullup_en | output | 9 | 1 = internal pull-up enabled |

## Verification
Results are due at three different times. A register write is due at the edge that samples the strobe, so the bench checks pin outputs and readback 1 ns after that edge. A pin level is due one edge later than a write, because it crosses two flops. The bench therefore applies levels at a falling edge, and confirms that the old value still reads after the first rising edge and the new value after the second. Read data is combinational, so the bench changes the address away from any edge and samples it 1 ns later, before the next edge.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int NPINS = 9;
    localparam int BYTE_W = 8;
    localparam logic [7:0] ADDR_PU_LO   = 8'hF0;
    localparam logic [7:0] ADDR_PU_HI   = 8'hF1;
    localparam logic [7:0] ADDR_CTL_LO  = 8'hF2;
    localparam logic [7:0] ADDR_CTL_HI  = 8'hF3;
    localparam logic [7:0] ADDR_STAT_LO = 8'hF8;
    localparam logic [7:0] ADDR_STAT_HI = 8'hF9;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpx_pair_reg.sv
module gpx_pair_reg #(
    parameter int               NBITS   = 9,
    parameter logic [7:0]       LO_ADDR = 8'hF0,
    parameter logic [7:0]       HI_ADDR = 8'hF1,
    parameter logic [NBITS-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    input  logic             we,
    output logic [NBITS-1:0] q
);
    logic wr_lo, wr_hi;
    assign wr_lo = we && (addr == LO_ADDR);
    assign wr_hi = we && (addr == HI_ADDR);

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        logic bit_q;
        if (i < 8) begin : g_lo
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     bit_q <= RST_VAL[i];
                else if (wr_lo) bit_q <= wdata[i];
            end
        end else begin : g_hi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     bit_q <= RST_VAL[i];
                else if (wr_hi) bit_q <= wdata[i-8];
            end
        end
        assign q[i] = bit_q;
    end
endmodule

// File: rtl/gpx_rdmux.sv
module gpx_rdmux #(
    parameter int NPINS = 9
) (
    input  logic [7:0]       addr,
    input  logic [NPINS-1:0] pu,
    input  logic [NPINS-1:0] ctl,
    input  logic [NPINS-1:0] lvl,
    output logic [7:0]       rdata
);
    import gpx_pkg::*;
    localparam int PADW = 16 - NPINS;

    logic [15:0] pu16, ctl16, lvl16;
    assign pu16  = {{PADW{1'b0}}, pu};
    assign ctl16 = {{PADW{1'b0}}, ctl};
    assign lvl16 = {{PADW{1'b0}}, lvl};

    always_comb begin
        unique case (addr)
            ADDR_PU_LO:   rdata = pu16[7:0];
            ADDR_PU_HI:   rdata = pu16[15:8];
            ADDR_CTL_LO:  rdata = ctl16[7:0];
            ADDR_CTL_HI:  rdata = ctl16[15:8];
            ADDR_STAT_LO: rdata = lvl16[7:0];
            ADDR_STAT_HI: rdata = lvl16[15:8];
            default:      rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/gpx_bank.sv
module gpx_bank #(
    parameter int NPINS       = gpx_pkg::NPINS,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic             reg_we,
    output logic [7:0]       reg_rdata,
    input  logic [NPINS-1:0] pin_level,
    output logic [NPINS-1:0] pin_drive_low,
    output logic [NPINS-1:0] pin_pullup_en
);
    import gpx_pkg::*;

    logic [NPINS-1:0] pu_q, ctl_q, lvl_q;

    gpx_pair_reg #(
        .NBITS(NPINS), .LO_ADDR(ADDR_PU_LO), .HI_ADDR(ADDR_PU_HI),
        .RST_VAL({NPINS{1'b0}})
    ) u_pu (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
        .we(reg_we), .q(pu_q)
    );

    gpx_pair_reg #(
        .NBITS(NPINS), .LO_ADDR(ADDR_CTL_LO), .HI_ADDR(ADDR_CTL_HI),
        .RST_VAL({NPINS{1'b1}})
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
        .we(reg_we), .q(ctl_q)
    );

    gpx_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_level), .q(lvl_q)
    );

    gpx_rdmux #(.NPINS(NPINS)) u_rd (
        .addr(reg_addr), .pu(pu_q), .ctl(ctl_q), .lvl(lvl_q), .rdata(reg_rdata)
    );

    assign pin_drive_low = ~ctl_q;
    assign pin_pullup_en = pu_q;
endmodule

// File: rtl/gpx_chk.sv
module gpx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       reg_we,
    input logic [7:0] reg_rdata,
    input logic [8:0] pin_drive_low,
    input logic [8:0] pin_pullup_en
);
    logic stat_wr, ctl_wr, pu_wr, mapped;
    assign stat_wr = reg_we && (reg_addr == 8'hF8 || reg_addr == 8'hF9);
    assign ctl_wr  = reg_we && (reg_addr == 8'hF2 || reg_addr == 8'hF3);
    assign pu_wr   = reg_we && (reg_addr == 8'hF0 || reg_addr == 8'hF1);
    assign mapped  = (reg_addr inside {8'hF0, 8'hF1, 8'hF2, 8'hF3, 8'hF8, 8'hF9});

    // R1
    reset_release_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (pin_drive_low == 9'h000 && pin_pullup_en == 9'h000));

    // R2
    pu_lo_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 8'hF0) |=> pin_pullup_en[7:0] == $past(reg_wdata));

    // R3
    ctl_lo_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 8'hF2) |=> pin_drive_low[7:0] == ~$past(reg_wdata));

    // R3
    ctl_hi_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 8'hF3) |=> pin_drive_low[8] == ~$past(reg_wdata[0]));

    // R6
    stat_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr || !(ctl_wr || pu_wr)) |=> ($stable(pin_drive_low) && $stable(pin_pullup_en)));

    // R7
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> reg_rdata == 8'h00);

    // R4
    hi_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'hF1 || reg_addr == 8'hF3 || reg_addr == 8'hF9) |-> reg_rdata[7:1] == 7'd0);
endmodule

bind gpx_bank gpx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .pin_drive_low(pin_drive_low),
    .pin_pullup_en(pin_pullup_en)
);

// File: tb/gpx_bank_tb.sv
`timescale 1ns/1ps
module gpx_bank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic [8:0] pin_level = 9'h000;
    logic [8:0] pin_drive_low, pin_pullup_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    gpx_bank u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .pin_level(pin_level),
        .pin_drive_low(pin_drive_low), .pin_pullup_en(pin_pullup_en)
    );

    // {we, waddr, wdata, raddr, expected read}
    localparam logic [32:0] VEC [9] = '{
        {1'b1, 8'hF0, 8'hA5, 8'hF0, 8'hA5},  // R2
        {1'b1, 8'hF1, 8'hFF, 8'hF1, 8'h01},  // R4
        {1'b1, 8'hF2, 8'h3C, 8'hF2, 8'h3C},  // R3
        {1'b1, 8'hF3, 8'hFE, 8'hF3, 8'h00},  // R3 R4
        {1'b1, 8'hF8, 8'h55, 8'hF0, 8'hA5},  // R6
        {1'b1, 8'h10, 8'h77, 8'h10, 8'h00},  // R7
        {1'b1, 8'hF9, 8'hFF, 8'hF2, 8'h3C},  // R6
        {1'b1, 8'hF1, 8'h00, 8'hF1, 8'h00},  // R2
        {1'b1, 8'hF4, 8'hAA, 8'hF4, 8'h00}   // R7
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic en);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = en;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 drive_low", {7'd0, pin_drive_low}, 16'h0000);
        check("R1 pullup", {7'd0, pin_pullup_en}, 16'h0000);
        rd(8'hF0, v); check("R1 F0", {8'd0, v}, 16'h0000);
        rd(8'hF1, v); check("R1 F1", {8'd0, v}, 16'h0000);
        rd(8'hF2, v); check("R1 F2", {8'd0, v}, 16'h00FF);
        rd(8'hF3, v); check("R1 F3", {8'd0, v}, 16'h0001);

        // table walk
        for (int i = 0; i < 9; i++) begin
            wr(VEC[i][31:24], VEC[i][23:16], VEC[i][32]);
            rd(VEC[i][15:8], v);
            check($sformatf("vec%0d R2/R3/R4/R6/R7", i), {8'd0, v}, {8'd0, VEC[i][7:0]});
        end
        // state after table: pu=0A5, ctl=03C (pin8 ctl 0)
        check("R3 drive_low after table", {7'd0, pin_drive_low}, {7'd0, ~9'h03C});
        check("R2 pullup after table", {7'd0, pin_pullup_en}, 16'h00A5);

        // R3 directed: control pattern
        wr(8'hF2, 8'h0F, 1'b1);
        wr(8'hF3, 8'h01, 1'b1);
        check("R3 drive_low 0F/01", {7'd0, pin_drive_low}, 16'h00F0);
        // R2 directed
        wr(8'hF0, 8'h81, 1'b1);
        wr(8'hF1, 8'h01, 1'b1);
        check("R2 pullup 81/01", {7'd0, pin_pullup_en}, 16'h0181);

        // R6: status writes leave outputs alone
        wr(8'hF8, 8'h00, 1'b1);
        wr(8'hF9, 8'h00, 1'b1);
        check("R6 drive_low kept", {7'd0, pin_drive_low}, 16'h00F0);
        check("R6 pullup kept", {7'd0, pin_pullup_en}, 16'h0181);

        // R5: two-flop latency on pin levels
        @(negedge clk) pin_level = 9'h1A5; reg_addr = 8'hF8;
        @(posedge clk); #1;
        check("R5 F8 after 1 edge", {8'd0, reg_rdata}, 16'h0000);
        @(posedge clk); #1;
        check("R5 F8 after 2 edges", {8'd0, reg_rdata}, 16'h00A5);
        rd(8'hF9, v); check("R5 F9", {8'd0, v}, 16'h0001);
        @(negedge clk) pin_level = 9'h05A;
        repeat (2) @(posedge clk);
        #1;
        rd(8'hF8, v); check("R5 F8 second", {8'd0, v}, 16'h005A);
        rd(8'hF9, v); check("R5 F9 second", {8'd0, v}, 16'h0000);

        // R8: reads are side-effect free and immediate
        rd(8'hF2, v); check("R8 read F2", {8'd0, v}, 16'h000F);
        rd(8'hF0, v); check("R8 switch to F0", {8'd0, v}, 16'h0081);
        repeat (3) @(posedge clk);
        #1;
        rd(8'hF2, v); check("R8 F2 repeat", {8'd0, v}, 16'h000F);
        rd(8'hFF, v); check("R7 FF unmapped", {8'd0, v}, 16'h0000);

        // R4: high bits of the upper bytes ignore writes
        wr(8'hF3, 8'hFE, 1'b1);
        rd(8'hF3, v); check("R4 F3 pad", {8'd0, v}, 16'h0000);
        check("R4 pin8 driven", {15'd0, pin_drive_low[8]}, 16'h0001);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule